// File: doc/BRIEF.md
# Watchdog Configuration Write Guard

This unit sits between the register bus and the configuration fields of a watchdog timer: the control word (enable, clock choice, prescale, early-service interrupt, window mode), the timeout value and the window value. It decides whether each bus write to those fields takes effect. Accepted writes leave the guard as a one-cycle strobe with the address and data. The counting logic that uses the fields lies outside this unit.

After reset the fields are open. The timeout and window words may be written freely. A write to the control word commits the setup and locks all fields. Once locked, the fields can be reopened only by writing two key words to a key address, the second no more than 16 clocks after the first. This opens an update window of 128 clocks, after which the fields lock again. A wrong key, or a second key that comes too late, raises a reset request. A seal bit in the control word makes the lock permanent until the next reset. Any key write while sealed raises a reset request.

Top module: `wdg_cfg_guard`

## Requirements
- R1: While and right after a synchronous reset, `lock_state` reads 0 (open), and `cfg_stb` and `reset_req` are low.
- R2: In the open state (0), a write to the timeout address (1) or the window address (2) is accepted: `cfg_stb` is high in the next cycle with the written address and data, and the state stays open.
- R3: In the open or unlocked state, a write to the control address (0) with bit 15 clear is accepted with a strobe and moves the state to locked (1) in the next cycle.
- R4: In the locked state, writes to addresses 0, 1 and 2 produce no strobe and do not change the state.
- R5: In the locked state, a write of 0x20C5 to the key address (3) followed by a write of 0x28D9 to it, at most 16 clocks later, moves the state to unlocked (2) in the cycle after the second write. A repeated 0x20C5 restarts the 16-clock limit.
- R6: In the locked state, a key write with any other value, or a 0x28D9 with no first key pending within the last 16 clocks, sets `reset_req` for one cycle in the next cycle and leaves the state locked.
- R7: In the unlocked state, configuration writes are accepted during the 128 cycles that follow entry. After the 128th cycle, the state returns to locked by itself.
- R8: In the open or unlocked state, a control write with bit 15 set is accepted with a strobe and moves the state to sealed (3).
- R9: In the sealed state, configuration writes are ignored. Every key write sets `reset_req` in the next cycle, and the state stays sealed until reset.
- R10: In the open and unlocked states, key writes have no effect: no strobe, no reset request and no change of state.
- R11: `cfg_stb` and `reset_req` are registered. Each rises only in the cycle after the write that causes it and lasts one cycle per write. Both are low in cycles that follow no write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Bus write valid |
| wr_addr | input | 2 | Write address: 0 control, 1 timeout, 2 window, 3 key |
| wr_data | input | 16 | Write data |
| cfg_stb | output | 1 | One-cycle strobe for an accepted configuration write |
| cfg_addr | output | 2 | Address of the accepted write |
| cfg_data | output | 16 | Data of the accepted write |
| reset_req | output | 1 | Reset request after a key violation |
| lock_state | output | 2 | 0 open, 1 locked, 2 unlocked, 3 sealed |

## Verification
Directed sequences put the key pair 16 clocks apart and then 17 clocks apart. The first separates an inclusive gap limit from an exclusive one, and the second separates a real timeout from no timeout. A write in the 128th unlocked cycle and a write in the 129th find the exact edge of the update window. Seal, wrong-key and sealed-key sequences cover the terminal state. Seeded random traffic, heavy in key words and with periodic resets, mixes out-of-order keys, re-armed first keys and writes in every state, and a bench model of the requirements checks each cycle.

// File: rtl/wdg_guard_pkg.sv
package wdg_guard_pkg;
  typedef enum logic [1:0] {
    LK_OPEN     = 2'd0,
    LK_LOCKED   = 2'd1,
    LK_UNLOCKED = 2'd2,
    LK_SEALED   = 2'd3
  } lk_state_t;
endpackage

// File: rtl/wdg_key_seq.sv
// Two-word key tracker: remembers a first key and how long ago it came.
module wdg_key_seq #(
  parameter int DATA_W = 16,
  parameter int GAP = 16,
  parameter logic [DATA_W-1:0] KEY_A = 'h20C5,
  parameter logic [DATA_W-1:0] KEY_B = 'h28D9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              key_wr,
  input  logic [DATA_W-1:0] key_data,
  output logic              key_pass,
  output logic              key_fail
);
  localparam int GW = $clog2(GAP + 1);

  logic          armed;
  logic [GW-1:0] gap;
  logic          is_a;
  logic          is_b;

  assign is_a     = (key_data == KEY_A);
  assign is_b     = (key_data == KEY_B);
  assign key_pass = key_wr && armed && is_b;
  assign key_fail = key_wr && !is_a && !(armed && is_b);

  always_ff @(posedge clk) begin
    if (rst) begin
      armed <= 1'b0;
      gap   <= '0;
    end else if (key_wr) begin
      armed <= is_a;
      gap   <= GW'(1);
    end else if (armed) begin
      if (gap == GW'(GAP)) armed <= 1'b0;
      else                 gap   <= gap + 1'b1;
    end
  end
endmodule

// File: rtl/wdg_upd_timer.sv
// Counts the cycles spent in the update window.
module wdg_upd_timer #(
  parameter int WIN = 128
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic run,
  output logic expire
);
  localparam int CW = (WIN > 2) ? $clog2(WIN) : 1;

  logic [CW-1:0] cnt;

  assign expire = run && !start && (cnt == CW'(WIN - 1));

  always_ff @(posedge clk) begin
    if (rst)        cnt <= '0;
    else if (start) cnt <= '0;
    else if (run)   cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/wdg_lock_fsm.sv
// Lock state register and write admission.
module wdg_lock_fsm
  import wdg_guard_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      cfg_wr,
  input  logic      ctrl_wr,
  input  logic      seal_bit,
  input  logic      key_wr,
  input  logic      key_pass,
  input  logic      key_fail,
  input  logic      expire,
  output lk_state_t state,
  output logic      accept,
  output logic      locked_key,
  output logic      entering_unl,
  output logic      viol
);
  lk_state_t nxt;

  assign accept       = cfg_wr && (state == LK_OPEN || state == LK_UNLOCKED);
  assign locked_key   = key_wr && (state == LK_LOCKED);
  assign entering_unl = locked_key && key_pass;
  assign viol         = (locked_key && key_fail) || (key_wr && state == LK_SEALED);

  always_comb begin
    nxt = state;
    unique case (state)
      LK_OPEN: begin
        if (accept && ctrl_wr) nxt = seal_bit ? LK_SEALED : LK_LOCKED;
      end
      LK_UNLOCKED: begin
        if (accept && ctrl_wr) nxt = seal_bit ? LK_SEALED : LK_LOCKED;
        else if (expire)       nxt = LK_LOCKED;
      end
      LK_LOCKED: begin
        if (entering_unl) nxt = LK_UNLOCKED;
      end
      default: nxt = LK_SEALED;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= LK_OPEN;
    else     state <= nxt;
  end
endmodule

// File: rtl/wdg_cfg_guard.sv
module wdg_cfg_guard
  import wdg_guard_pkg::*;
#(
  parameter int ADDR_W = 2,
  parameter int DATA_W = 16,
  parameter int KEY_GAP = 16,
  parameter int UPD_WIN = 128,
  parameter int SEAL_POS = 15,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 'd0,
  parameter logic [ADDR_W-1:0] KEY_ADDR = 'd3,
  parameter logic [DATA_W-1:0] KEY_A = 'h20C5,
  parameter logic [DATA_W-1:0] KEY_B = 'h28D9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              cfg_stb,
  output logic [ADDR_W-1:0] cfg_addr,
  output logic [DATA_W-1:0] cfg_data,
  output logic              reset_req,
  output logic [1:0]        lock_state
);
  logic      key_wr;
  logic      cfg_wr;
  logic      ctrl_wr;
  logic      key_pass;
  logic      key_fail;
  logic      expire;
  logic      accept;
  logic      locked_key;
  logic      entering_unl;
  logic      viol;
  lk_state_t state;

  assign key_wr  = wr_en && (wr_addr == KEY_ADDR);
  assign cfg_wr  = wr_en && (wr_addr != KEY_ADDR);
  assign ctrl_wr = wr_addr == CTRL_ADDR;

  wdg_key_seq #(
    .DATA_W(DATA_W), .GAP(KEY_GAP), .KEY_A(KEY_A), .KEY_B(KEY_B)
  ) keys_i (
    .clk(clk), .rst(rst), .key_wr(locked_key), .key_data(wr_data),
    .key_pass(key_pass), .key_fail(key_fail)
  );

  wdg_upd_timer #(.WIN(UPD_WIN)) timer_i (
    .clk(clk), .rst(rst), .start(entering_unl),
    .run(state == LK_UNLOCKED), .expire(expire)
  );

  wdg_lock_fsm fsm_i (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .ctrl_wr(ctrl_wr),
    .seal_bit(wr_data[SEAL_POS]), .key_wr(key_wr), .key_pass(key_pass),
    .key_fail(key_fail), .expire(expire), .state(state), .accept(accept),
    .locked_key(locked_key), .entering_unl(entering_unl), .viol(viol)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_stb   <= 1'b0;
      cfg_addr  <= '0;
      cfg_data  <= '0;
      reset_req <= 1'b0;
    end else begin
      cfg_stb   <= accept;
      reset_req <= viol;
      if (accept) begin
        cfg_addr <= wr_addr;
        cfg_data <= wr_data;
      end
    end
  end

  assign lock_state = state;
endmodule

// File: rtl/wdg_cfg_guard_chk.sv
module wdg_cfg_guard_chk #(
  parameter int ADDR_W = 2,
  parameter int UPD_WIN = 128,
  parameter logic [ADDR_W-1:0] KEY_ADDR = 'd3
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic              cfg_stb,
  input logic              reset_req,
  input logic [1:0]        lock_state
);
  localparam int UW = $clog2(UPD_WIN) + 2;
  logic [UW-1:0] unl_cycles;

  always_ff @(posedge clk) begin
    if (rst)                     unl_cycles <= '0;
    else if (lock_state == 2'd2) unl_cycles <= unl_cycles + 1'b1;
    else                         unl_cycles <= '0;
  end

  assert_stb_from_open_state_R4: assert property (@(posedge clk) disable iff (rst)
    cfg_stb |-> ($past(lock_state) == 2'd0 || $past(lock_state) == 2'd2));

  assert_unlock_only_from_locked_R5: assert property (@(posedge clk) disable iff (rst)
    (lock_state == 2'd2 && $past(lock_state) != 2'd2) |-> $past(lock_state) == 2'd1);

  assert_reset_req_after_key_R6: assert property (@(posedge clk) disable iff (rst)
    reset_req |-> $past(wr_en && wr_addr == KEY_ADDR));

  assert_window_bounded_R7: assert property (@(posedge clk) disable iff (rst)
    unl_cycles <= UW'(UPD_WIN));

  assert_seal_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    lock_state == 2'd3 |=> lock_state == 2'd3);

  assert_exclusive_pulses_R11: assert property (@(posedge clk) disable iff (rst)
    !(cfg_stb && reset_req));
endmodule

bind wdg_cfg_guard wdg_cfg_guard_chk #(
  .ADDR_W(ADDR_W), .UPD_WIN(UPD_WIN), .KEY_ADDR(KEY_ADDR)
) chk_i (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
  .cfg_stb(cfg_stb), .reset_req(reset_req), .lock_state(lock_state)
);

// File: tb/wdg_cfg_guard_tb_top.sv
module wdg_cfg_guard_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        cfg_stb;
  logic [1:0]  cfg_addr;
  logic [15:0] cfg_data;
  logic        reset_req;
  logic [1:0]  lock_state;

  int total = 0;
  int bad = 0;
  bit done = 0;

  int m_st = 0;
  bit m_armed = 0;
  int m_gap = 0;
  int m_upd = 0;

  always #2.5 clk = ~clk;

  wdg_cfg_guard dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .cfg_stb(cfg_stb), .cfg_addr(cfg_addr), .cfg_data(cfg_data),
    .reset_req(reset_req), .lock_state(lock_state)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; wr_en = 1'b0;
    repeat (2) @(posedge clk);
    #1;
    chk("R1", "lock_state", lock_state, 0);
    chk("R1", "cfg_stb", cfg_stb, 0);
    chk("R1", "reset_req", reset_req, 0);
    @(negedge clk);
    rst = 1'b0;
    m_st = 0; m_armed = 0; m_gap = 0; m_upd = 0;
  endtask

  // One bus cycle; the model follows the requirements.
  task automatic cyc(input bit en, input logic [1:0] a, input logic [15:0] d);
    bit is_key, is_cfg, e_stb, e_rr;
    int ns;
    string tag;
    is_key = en && a == 2'd3;
    is_cfg = en && a != 2'd3;
    e_stb = 0; e_rr = 0; ns = m_st; tag = "R11";
    case (m_st)
      0: begin
        if (is_cfg) begin
          e_stb = 1; tag = "R2";
          if (a == 2'd0) begin ns = d[15] ? 3 : 1; tag = d[15] ? "R8" : "R3"; end
        end else if (is_key) tag = "R10";
      end
      2: begin
        if (is_key) tag = "R10";
        if (is_cfg) begin
          e_stb = 1; tag = "R7";
          if (a == 2'd0) begin ns = d[15] ? 3 : 1; tag = d[15] ? "R8" : "R3"; end
        end
        if (ns == 2 && m_upd == 127) begin ns = 1; tag = "R7"; end
        m_upd++;
      end
      1: begin
        if (is_cfg) tag = "R4";
        if (is_key) begin
          if (m_armed && d == 16'h28D9) begin ns = 2; m_upd = 0; m_armed = 0; tag = "R5"; end
          else if (d == 16'h20C5) begin m_armed = 1; m_gap = 1; tag = "R5"; end
          else begin e_rr = 1; m_armed = 0; tag = "R6"; end
        end else if (m_armed) begin
          if (m_gap == 16) m_armed = 0; else m_gap++;
        end
      end
      default: begin
        tag = "R9";
        if (is_key) e_rr = 1;
      end
    endcase
    m_st = ns;
    @(negedge clk);
    wr_en = en; wr_addr = a; wr_data = d;
    @(posedge clk);
    #1;
    chk(tag, "cfg_stb", cfg_stb, e_stb);
    chk(tag, "reset_req", reset_req, e_rr);
    chk(tag, "lock_state", lock_state, m_st);
    if (e_stb) begin
      chk(tag, "cfg_addr", cfg_addr, a);
      chk(tag, "cfg_data", cfg_data, d);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(0, 2'd0, 16'h0);
  endtask

  task automatic unlock();
    cyc(1, 2'd3, 16'h20C5);
    cyc(1, 2'd3, 16'h28D9);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    do_reset();
    // R2 and R10 in the open state
    cyc(1, 2'd1, 16'hBEEF);
    cyc(1, 2'd2, 16'h0100);
    cyc(1, 2'd3, 16'h20C5);
    cyc(1, 2'd3, 16'h1111);
    // R3 commit and lock
    cyc(1, 2'd0, 16'h0001);
    // R4 ignored writes
    cyc(1, 2'd1, 16'h5555);
    cyc(1, 2'd0, 16'h0002);
    // R5 gap exactly 16
    cyc(1, 2'd3, 16'h20C5);
    idle(15);
    cyc(1, 2'd3, 16'h28D9);
    // R7 window edges
    cyc(1, 2'd1, 16'h0A0A);
    idle(126);
    cyc(1, 2'd2, 16'h0B0B);
    cyc(1, 2'd2, 16'h0C0C);
    // R6 late second key (gap 17) and wrong key
    cyc(1, 2'd3, 16'h20C5);
    idle(16);
    cyc(1, 2'd3, 16'h28D9);
    cyc(1, 2'd3, 16'h1234);
    // R5 re-armed first key then pass; R10 key inside window
    cyc(1, 2'd3, 16'h20C5);
    idle(10);
    cyc(1, 2'd3, 16'h20C5);
    idle(12);
    cyc(1, 2'd3, 16'h28D9);
    cyc(1, 2'd3, 16'h9999);
    // R8 seal while unlocked, R9 afterwards
    cyc(1, 2'd0, 16'h8003);
    cyc(1, 2'd1, 16'h7777);
    cyc(1, 2'd3, 16'h20C5);
    cyc(1, 2'd3, 16'h28D9);
    idle(3);
    // R8 seal before first configuration
    do_reset();
    cyc(1, 2'd0, 16'h8000);
    cyc(1, 2'd2, 16'h0001);
    // random traffic
    for (int blk = 0; blk < 10; blk++) begin
      do_reset();
      for (int i = 0; i < 300; i++) begin
        int r;
        r = $urandom % 16;
        if (r < 6)       cyc(0, 2'd0, 16'h0);
        else if (r < 9)  cyc(1, 2'(1 + $urandom % 2), 16'($urandom));
        else if (r == 9) cyc(1, 2'd0, {($urandom % 8 == 0), 15'($urandom)});
        else if (r < 13) cyc(1, 2'd3, 16'h20C5);
        else if (r < 15) cyc(1, 2'd3, 16'h28D9);
        else             cyc(1, 2'd3, 16'($urandom));
      end
    end
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule